// File: doc/BRIEF.md
# Seven-Level Priority Interrupt Controller

The controller gathers seven level-sensitive interrupt request lines and a non-maskable request, and presents to a processor core the highest priority that is currently requested, together with the autovector number for that priority. Each request line goes through a two-flop synchronizer into an 8-bit pending register whose bits follow the line levels. A registered priority encoder turns the pending register into a 3-bit level and an 8-bit vector. The non-maskable request acts on line 6, the top priority.

Each line also has a saturating event counter that counts the rising edges of its pending bit. Software reads the pending register and the counters through a small read port. The read port uses a valid/ready request channel and a valid/ready response channel. A request is accepted on a clock edge where `rd_req_valid_i` and `rd_req_ready_o` are both high. The response then appears on the next cycle and holds with stable data until `rd_rsp_ready_i` is high. `rd_req_ready_o` is low while an unconsumed response is held, so only one read is ever in flight.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Synchronous reset (active high `rst`) clears the pending register, every event counter and the response valid, and drives level and vector to 0.
- R2: Pending bit i (i = 0..6) equals request line i after a two-flop synchronizer and a register, so a change on `irq_i[i]` reaches the pending register on the third rising clock edge. Pending bit 7 always reads 0.
- R3: The level output is one plus the highest index whose pending bit is set (line 6 gives level 7, line 0 gives level 1). The vector output is that index plus `VEC_BASE`, which defaults to 25, so levels 1..7 give vectors 25..31.
- R4: When no pending bit is set, the level and vector outputs are both 0.
- R5: Level and vector are registered and change on the clock edge after the pending register changes, four edges after the request line.
- R6: A high `nmi_i` sets pending bit 6 through its own two-flop synchronizer, giving level 7 whatever the request lines are.
- R7: The counter for line i increments by one on each rising edge of pending bit i, not on every cycle that the bit stays high.
- R8: A counter that holds all ones stays at all ones on further edges.
- R9: Read address 0 returns the pending register in bits 7:0 with zeros above. Address 2*i+1 returns bits 31:0 of counter i and address 2*i+2 returns bits 63:32, zero-extended for counters narrower than 64 bits. Any other address returns 0.
- R10: While the response is valid and `rd_rsp_ready_i` is low, the response data stays stable and `rd_req_ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_i | input | 7 | Level-sensitive request lines, index i is level i+1 |
| nmi_i | input | 1 | Non-maskable request, acts on line 6 |
| level_o | output | 3 | Highest pending priority level, 0 when idle |
| vector_o | output | 8 | Autovector number, 0 when idle |
| rd_req_valid_i | input | 1 | Read request valid |
| rd_req_ready_o | output | 1 | Read request ready |
| rd_addr_i | input | 4 | Read address |
| rd_rsp_valid_o | output | 1 | Read response valid |
| rd_rsp_ready_i | input | 1 | Read response ready |
| rd_rsp_data_o | output | 32 | Read response data |

## Verification
Counter saturation is the hardest condition to reach from the ports, because a 64-bit counter can never fill in a simulation. The bench therefore builds the controller with 4-bit counters and pulses one line more than fifteen times. It then reads the counter back through the port and checks that the high half is still zero-extended. The one-cycle gap between the pending register and the outputs is checked by sampling the level on the edge just before it is due to change and on the edge after.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned IRQC_DATA_W = 32;
  localparam int unsigned IRQC_WIDE_W = 64;

  typedef logic [IRQC_DATA_W-1:0] irqc_word_t;
  typedef logic [IRQC_WIDE_W-1:0] irqc_wide_t;

  // Select the half of a wide value for a read word
  function automatic irqc_word_t irqc_half(input irqc_wide_t v, input logic hi);
    return hi ? v[IRQC_WIDE_W-1:IRQC_DATA_W] : v[IRQC_DATA_W-1:0];
  endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_evt_cnt.sv
module irqc_evt_cnt #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             full;

  assign full = &cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (inc_i && !full) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
  parameter int unsigned LINES    = 7,
  parameter int unsigned PEND_W   = 8,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 25,
  localparam int unsigned LVL_W   = $clog2(LINES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PEND_W-1:0] pend_i,
  output logic [LVL_W-1:0]  level_o,
  output logic [VEC_W-1:0]  vector_o
);
  logic [LVL_W-1:0] level_d;
  logic [VEC_W-1:0] vector_d;
  logic [LVL_W-1:0] level_q;
  logic [VEC_W-1:0] vector_q;

  // Ascending scan: the last set bit, i.e. the highest index, wins
  always_comb begin
    level_d  = '0;
    vector_d = '0;
    for (int i = 0; i < int'(LINES); i++) begin
      if (pend_i[i]) begin
        level_d  = LVL_W'(i + 1);
        vector_d = VEC_W'(int'(VEC_BASE) + i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q  <= '0;
      vector_q <= '0;
    end else begin
      level_q  <= level_d;
      vector_q <= vector_d;
    end
  end

  assign level_o  = level_q;
  assign vector_o = vector_q;
endmodule

// File: rtl/irqc_rd_port.sv
module irqc_rd_port
  import irqc_pkg::*;
#(
  parameter int unsigned LINES  = 7,
  parameter int unsigned PEND_W = 8,
  parameter int unsigned CNT_W  = 64,
  localparam int unsigned ADDR_W = $clog2(2 * LINES + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [PEND_W-1:0]           pend_i,
  input  logic [LINES-1:0][CNT_W-1:0] cnt_i,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [ADDR_W-1:0]           addr_i,
  output logic                        rsp_valid_o,
  input  logic                        rsp_ready_i,
  output irqc_word_t                  rsp_data_o
);
  irqc_word_t rd_mux;
  irqc_wide_t wide;
  logic       rsp_valid_q;
  irqc_word_t rsp_data_q;
  logic       accept;

  always_comb begin
    rd_mux = '0;
    wide   = '0;
    if (addr_i == '0) begin
      rd_mux[PEND_W-1:0] = pend_i;
    end
    for (int i = 0; i < int'(LINES); i++) begin
      if (int'(addr_i) == 2 * i + 1 || int'(addr_i) == 2 * i + 2) begin
        wide            = '0;
        wide[CNT_W-1:0] = cnt_i[i];
        rd_mux          = irqc_half(wide, int'(addr_i) == 2 * i + 2);
      end
    end
  end

  assign req_ready_o = !rsp_valid_q || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_mux;
    end else if (rsp_ready_i) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned LINES    = 7,
  parameter int unsigned PEND_W   = 8,
  parameter int unsigned CNT_W    = 64,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 25,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [LINES-1:0]               irq_i,
  input  logic                           nmi_i,
  output logic [$clog2(LINES+1)-1:0]     level_o,
  output logic [VEC_W-1:0]               vector_o,
  input  logic                           rd_req_valid_i,
  output logic                           rd_req_ready_o,
  input  logic [$clog2(2*LINES+1)-1:0]   rd_addr_i,
  output logic                           rd_rsp_valid_o,
  input  logic                           rd_rsp_ready_i,
  output logic [IRQC_DATA_W-1:0]         rd_rsp_data_o
);
  localparam int unsigned TOP = LINES - 1;

  logic [LINES:0]              sync_all;
  logic [LINES-1:0]            line_eff;
  logic [PEND_W-1:0]           pend_q;
  logic [LINES-1:0]            rise;
  logic [LINES-1:0][CNT_W-1:0] cnt_q;

  // Request lines and the non-maskable request share one synchronizer bank
  irqc_sync #(.W(LINES + 1), .STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({nmi_i, irq_i}),
    .q_o (sync_all)
  );

  always_comb begin
    line_eff      = sync_all[LINES-1:0];
    line_eff[TOP] = sync_all[TOP] | sync_all[LINES];
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else begin
      pend_q              <= '0;
      pend_q[LINES-1:0]   <= line_eff;
    end
  end

  assign rise = line_eff & ~pend_q[LINES-1:0];

  for (genvar g = 0; g < int'(LINES); g++) begin : g_cnt
    irqc_evt_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc_i (rise[g]),
      .cnt_o (cnt_q[g])
    );
  end

  irqc_prio_enc #(
    .LINES(LINES), .PEND_W(PEND_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
  ) u_enc (
    .clk      (clk),
    .rst      (rst),
    .pend_i   (pend_q),
    .level_o  (level_o),
    .vector_o (vector_o)
  );

  irqc_rd_port #(.LINES(LINES), .PEND_W(PEND_W), .CNT_W(CNT_W)) u_rd (
    .clk         (clk),
    .rst         (rst),
    .pend_i      (pend_q),
    .cnt_i       (cnt_q),
    .req_valid_i (rd_req_valid_i),
    .req_ready_o (rd_req_ready_o),
    .addr_i      (rd_addr_i),
    .rsp_valid_o (rd_rsp_valid_o),
    .rsp_ready_i (rd_rsp_ready_i),
    .rsp_data_o  (rd_rsp_data_o)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int unsigned LINES    = 7,
  parameter int unsigned PEND_W   = 8,
  parameter int unsigned CNT_W    = 64,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 25
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        nmi_i,
  input logic [PEND_W-1:0]           pend,
  input logic [$clog2(LINES+1)-1:0]  level,
  input logic [VEC_W-1:0]            vector,
  input logic                        rsp_valid,
  input logic                        rsp_ready,
  input logic                        req_ready,
  input logic [31:0]                 rsp_data,
  input logic [LINES-1:0][CNT_W-1:0] cnt
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(pend[LINES-1:0]) == '0 |-> (level == '0 && vector == '0)); // R4

  AST_TOP_WINS: assert property (@(posedge clk) disable iff (rst)
    $past(pend[LINES-1]) |-> int'(level) == int'(LINES)); // R3

  AST_VEC_MAP: assert property (@(posedge clk) disable iff (rst)
    level != '0 |-> int'(vector) == int'(VEC_BASE) + int'(level) - 1); // R3

  AST_NMI_TOP: assert property (@(posedge clk) disable iff (rst)
    ($past(nmi_i, 3) && !$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3))
      |-> pend[LINES-1]); // R6

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R10

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R10

  for (genvar g = 0; g < int'(LINES); g++) begin : g_sat
    AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
      (&$past(cnt[g])) |-> (&cnt[g])); // R8
  end
endmodule

bind prio_irq_ctrl irqc_checker #(
  .LINES(LINES), .PEND_W(PEND_W), .CNT_W(CNT_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .nmi_i     (nmi_i),
  .pend      (pend_q),
  .level     (level_o),
  .vector    (vector_o),
  .rsp_valid (rd_rsp_valid_o),
  .rsp_ready (rd_rsp_ready_i),
  .req_ready (rd_req_ready_o),
  .rsp_data  (rd_rsp_data_o),
  .cnt       (cnt_q)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  irq = '0;
  logic        nmi = 1'b0;
  logic [2:0]  level;
  logic [7:0]  vector;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;

  int errors = 0;
  int checks = 0;
  int exp_cnt [7];
  logic [6:0] eff_prev = '0;

  always #10 clk = ~clk;

  prio_irq_ctrl #(.CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .irq_i(irq), .nmi_i(nmi),
    .level_o(level), .vector_o(vector),
    .rd_req_valid_i(req_valid), .rd_req_ready_o(req_ready), .rd_addr_i(addr),
    .rd_rsp_valid_o(rsp_valid), .rd_rsp_ready_i(rsp_ready), .rd_rsp_data_o(rsp_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_level(input logic [6:0] p);
    for (int i = 6; i >= 0; i--) if (p[i]) return i + 1;
    return 0;
  endfunction

  function automatic int exp_vector(input logic [6:0] p);
    int l = exp_level(p);
    return (l == 0) ? 0 : 24 + l;
  endfunction

  // Drive lines, update the counter model, let everything settle
  task automatic set_lines(input logic [6:0] r, input logic n);
    logic [6:0] eff = r | {n, 6'b0};
    for (int i = 0; i < 7; i++)
      if (eff[i] && !eff_prev[i] && exp_cnt[i] < CMAX) exp_cnt[i]++;
    eff_prev = eff;
    @(negedge clk);
    irq = r;
    nmi = n;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_data : 32'hDEAD_BEEF;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 level after reset", 32'(level), 0);
    check("R1 vector after reset", 32'(vector), 0);
    check("R1 rsp_valid after reset", 32'(rsp_valid), 0);
    do_read(4'd0, d); check("R1 pending after reset", d, 0);
    do_read(4'd13, d); check("R1 counter 6 after reset", d, 0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    irq = 7'b0000100;
    eff_prev = 7'b0000100;
    exp_cnt[2]++;
    repeat (3) @(negedge clk);
    check("R5 level before due edge", 32'(level), 0);
    @(negedge clk);
    check("R5 level on due edge", 32'(level), 3);
    check("R5 vector on due edge", 32'(vector), 27);
    set_lines(7'b0, 1'b0);
    check("R4 level idle", 32'(level), 0);
  endtask

  task automatic t_priority;
    logic [6:0] pats [4] = '{7'b0000101, 7'b0101010, 7'b1111111, 7'b0000001};
    logic [31:0] d;
    foreach (pats[k]) begin
      set_lines(pats[k], 1'b0);
      check("R3 level", 32'(level), 32'(exp_level(pats[k])));
      check("R3 vector", 32'(vector), 32'(exp_vector(pats[k])));
      do_read(4'd0, d);
      check("R2 pending readout", d, 32'(pats[k]));
    end
    set_lines(7'b0, 1'b0);
    check("R4 level zero", 32'(level), 0);
    check("R4 vector zero", 32'(vector), 0);
  endtask

  task automatic t_nmi;
    logic [31:0] d;
    set_lines(7'b0000011, 1'b1);
    check("R6 nmi level", 32'(level), 7);
    check("R6 nmi vector", 32'(vector), 31);
    do_read(4'd0, d);
    check("R6 nmi pending bit 6", d, 32'h43);
    set_lines(7'b0, 1'b0);
    check("R6 nmi released", 32'(level), 0);
  endtask

  task automatic t_count;
    logic [31:0] d;
    for (int p = 0; p < 3; p++) begin
      set_lines(7'b0010000, 1'b0);
      repeat (5) @(negedge clk);
      set_lines(7'b0, 1'b0);
    end
    do_read(4'd9, d);
    check("R7 counter 4 counts edges", d, 32'(exp_cnt[4]));
  endtask

  task automatic t_saturate;
    logic [31:0] d;
    for (int p = 0; p < CMAX + 4; p++) begin
      set_lines(7'b0000001, 1'b0);
      set_lines(7'b0, 1'b0);
    end
    do_read(4'd1, d);
    check("R8 counter 0 saturated", d, CMAX);
    do_read(4'd2, d);
    check("R9 counter 0 high half", d, 0);
  endtask

  task automatic t_readmap;
    logic [31:0] d;
    for (int i = 0; i < 7; i++) begin
      do_read(4'(2 * i + 1), d);
      check("R9 counter low half", d, 32'(exp_cnt[i]));
      do_read(4'(2 * i + 2), d);
      check("R9 counter high half", d, 0);
    end
    do_read(4'd15, d);
    check("R9 unmapped address", d, 0);
  endtask

  task automatic t_backpressure;
    logic [31:0] held;
    set_lines(7'b0100000, 1'b0);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1;
    addr = 4'd0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 response valid", 32'(rsp_valid), 1);
    held = rsp_data;
    check("R10 held data", held, 32'h20);
    irq = 7'b0;
    repeat (5) @(negedge clk);
    check("R10 request blocked", 32'(req_ready), 0);
    check("R10 data stable", rsp_data, held);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R10 response consumed", 32'(rsp_valid), 0);
    eff_prev = 7'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    foreach (exp_cnt[i]) exp_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latency();
    t_priority();
    t_nmi();
    t_count();
    t_saturate();
    t_readmap();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule